// File: doc/BRIEF.md
# Packed-Byte Vector Lane Loader

This block performs the load half of a packed-byte transfer into an eight-lane vector register. Each lane is 16 bits wide. A request supplies four things: a byte address, a starting element number, a placement mode and a 16-byte memory window. The window is the aligned 16-byte line that holds the address. The block picks one byte from the window for every lane and expands it into that lane. The result is registered, so the loaded vector and a one-cycle done pulse appear on the clock edge after the request.

The byte for each lane is chosen by rotation. The starting element sets which lane receives the byte at the address. Lanes before it take bytes from the end of the 16-byte line, wrapping modulo 16. The address only needs 8-byte alignment. Its bit 3 selects the upper or lower half of the line as the starting point. Its low three bits take no part in the load. In packed mode the byte becomes the top eight bits of the lane. In unsigned mode it sits one bit lower, at bits 14:7. All lane bits that receive no byte are zero.

Top module: `pbyte_lane_loader`

## Requirements
- R1: Lane i takes window byte ((8*addr_i[3] + i - elem_i) mod 16). Window byte k is mem_line_i[8k+7:8k].
- R2: With elem_i = 0 and addr_i[3] = 0, lanes 0..7 take window bytes 0..7. With elem_i = 1, lane 0 takes byte 15 and lane 1 takes byte 0.
- R3: In packed mode (mode_i = 0) the byte is placed in lane bits 15:8. Lane bits 7:0 are zero.
- R4: In unsigned mode (mode_i = 1) the byte is placed in lane bits 14:7. Lane bit 15 and bits 6:0 are zero.
- R5: Bits 2:0 of addr_i have no effect on the result. line_addr_o equals addr_i with bits 3:0 cleared, combinationally.
- R6: done_o is high in exactly the cycles that follow a cycle with req_valid_i high. The result for that request is visible at the same time.
- R7: While req_valid_i is low, result_o keeps its value.
- R8: After reset, result_o is all zero and done_o is low.
- R9: Element numbers 8..15 follow the same modulo-16 rule as 0..7.
- R10: Requests in consecutive cycles each produce a done cycle. result_o then shows the result of the most recent request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Load request |
| addr_i | input | 32 | Byte address, 8-byte aligned |
| elem_i | input | 4 | Starting element number |
| mode_i | input | 1 | 0 = packed (bits 15:8), 1 = unsigned (bits 14:7) |
| line_addr_o | output | 32 | Address of the aligned 16-byte line |
| mem_line_i | input | 128 | The 16 bytes of the line, byte k at bits 8k+7:8k |
| done_o | output | 1 | Pulse one cycle after a request |
| result_o | output | 128 | Destination vector, lane i at bits 16i+15:16i |

## Verification
Two events can fall in the same cycle: the done pulse of one load and the capture of the next request. The bench provokes this by holding req_valid_i high across two edges, with a different element, mode and window each time. It then checks that done_o stays high and that result_o changes to the second load's expected vector. Every other load is isolated by an idle cycle. In those idle cycles the bench checks that done_o drops and result_o holds.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  typedef enum logic {
    MODE_PACKED   = 1'b0,
    MODE_UNSIGNED = 1'b1
  } pbl_mode_e;
endpackage

// File: rtl/pbl_byte_sel.sv
module pbl_byte_sel #(
  parameter int LANE      = 0,
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 16,
  localparam int IDX_W    = $clog2(WIN_BYTES)
) (
  input  logic [IDX_W-1:0]            base_i,
  input  logic [IDX_W-1:0]            elem_i,
  input  logic [WIN_BYTES*BYTE_W-1:0] line_i,
  output logic [BYTE_W-1:0]           byte_o
);
  logic [IDX_W-1:0] idx;

  // rotation wraps naturally in IDX_W bits
  always_comb begin
    idx    = base_i + IDX_W'(LANE) - elem_i;
    byte_o = line_i[idx*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/pbl_lane_place.sv
module pbl_lane_place
  import pbl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANE_W = 16
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  pbl_mode_e         mode_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int PK_LSB = LANE_W - BYTE_W;
  localparam int US_LSB = LANE_W - BYTE_W - 1;

  always_comb begin
    lane_o = '0;
    if (mode_i == MODE_UNSIGNED) lane_o[US_LSB +: BYTE_W] = byte_i;
    else                         lane_o[PK_LSB +: BYTE_W] = byte_i;
  end
endmodule

// File: rtl/pbyte_lane_loader.sv
module pbyte_lane_loader
  import pbl_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 8,
  parameter int LANE_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 16,
  localparam int IDX_W    = $clog2(WIN_BYTES),
  localparam int ALIGN_W  = $clog2(LANES),
  localparam int LINE_W   = WIN_BYTES * BYTE_W,
  localparam int VEC_W    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  elem_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] line_addr_o,
  input  logic [LINE_W-1:0] mem_line_i,
  output logic              done_o,
  output logic [VEC_W-1:0]  result_o
);
  logic [IDX_W-1:0] base;
  logic [VEC_W-1:0] vec_nxt;
  pbl_mode_e        mode;

  assign mode        = pbl_mode_e'(mode_i);
  assign line_addr_o = {addr_i[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  // sub-alignment bits dropped
  assign base        = {addr_i[IDX_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] sel_byte;

    pbl_byte_sel #(
      .LANE      (g),
      .BYTE_W    (BYTE_W),
      .WIN_BYTES (WIN_BYTES)
    ) u_sel (
      .base_i (base),
      .elem_i (elem_i),
      .line_i (mem_line_i),
      .byte_o (sel_byte)
    );

    pbl_lane_place #(
      .BYTE_W (BYTE_W),
      .LANE_W (LANE_W)
    ) u_place (
      .byte_i (sel_byte),
      .mode_i (mode),
      .lane_o (vec_nxt[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= req_valid_i;
      if (req_valid_i) result_o <= vec_nxt;
    end
  end
endmodule

// File: rtl/pbl_checker.sv
module pbl_checker #(
  parameter int LANES  = 8,
  parameter int LANE_W = 16,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [IDX_W-1:0]        elem_i,
  input logic                    mode_i,
  input logic [LINE_W-1:0]       mem_line_i,
  input logic                    done_o,
  input logic [LANES*LANE_W-1:0] result_o
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o); // R6
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(result_o)); // R7
  AST_LANE0_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && elem_i == '0 && addr_i[3] == 1'b0 && mode_i == 1'b0)
    |=> result_o[LANE_W-1 -: BYTE_W] == $past(mem_line_i[BYTE_W-1:0])); // R2

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_PACKED_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !mode_i) |=> result_o[l*LANE_W +: LANE_W-BYTE_W] == '0); // R3
    AST_UNS_EDGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && mode_i) |=> (result_o[l*LANE_W + LANE_W-1] == 1'b0 &&
        result_o[l*LANE_W +: LANE_W-BYTE_W-1] == '0)); // R4
  end
endmodule

bind pbyte_lane_loader pbl_checker #(
  .LANES  (LANES),
  .LANE_W (LANE_W),
  .BYTE_W (BYTE_W),
  .IDX_W  (IDX_W),
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .addr_i      (addr_i),
  .elem_i      (elem_i),
  .mode_i      (mode_i),
  .mem_line_i  (mem_line_i),
  .done_o      (done_o),
  .result_o    (result_o)
);

// File: tb/pbyte_lane_loader_tb.sv
module pbyte_lane_loader_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [31:0]  addr = '0;
  logic [3:0]   elem = '0;
  logic         mode = 1'b0;
  logic [127:0] line = '0;
  logic [31:0]  line_addr;
  logic         done;
  logic [127:0] result;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pbyte_lane_loader u_dut (
    .clk_i (clk), .rst_ni (rst_n), .req_valid_i (req), .addr_i (addr),
    .elem_i (elem), .mode_i (mode), .line_addr_o (line_addr),
    .mem_line_i (line), .done_o (done), .result_o (result)
  );

  function automatic logic [127:0] mk_line(int seed);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'(k*17 + seed*5 + 3);
    return v;
  endfunction

  function automatic logic [127:0] expect_vec(logic [31:0] a, logic [3:0] e,
                                              logic m, logic [127:0] ln);
    logic [127:0] v = '0;
    for (int i = 0; i < 8; i++) begin
      int idx = (8*a[3] + i - e + 16) % 16;
      logic [7:0] b = ln[idx*8 +: 8];
      v[i*16 +: 16] = m ? {1'b0, b, 7'b0} : {b, 8'b0};
    end
    return v;
  endfunction

  task automatic check(string req_tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // drive at negedge, check one edge later
  task automatic load(logic [31:0] a, logic [3:0] e, logic m, int seed, string tag);
    logic [127:0] exp;
    addr = a; elem = e; mode = m; line = mk_line(seed); req = 1'b1;
    exp = expect_vec(a, e, m, line);
    #1 check("R5 line_addr", 128'(line_addr), 128'({a[31:4], 4'b0}));
    @(negedge clk);
    req = 1'b0;
    check("R6 done", 128'(done), 128'(1));
    check(tag, result, exp);
    @(negedge clk);
    check("R6 done low", 128'(done), 128'(0));
    check("R7 hold", result, exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [127:0] e1;
    logic [127:0] e2;
    #3 check("R8 reset result", result, '0);
    check("R8 reset done", 128'(done), 128'(0));
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2 named cases
    load(32'h100, 4'd0, 1'b0, 1, "R2 e0");
    load(32'h100, 4'd1, 1'b0, 2, "R2 e1");

    // exhaustive sweep: half select, element, mode (R1 R3 R4 R9)
    for (int h = 0; h < 2; h++)
      for (int e = 0; e < 16; e++)
        for (int m = 0; m < 2; m++)
          load(32'h2000 + 32'(h*8), 4'(e), 1'(m), h*32 + e*2 + m,
               e >= 8 ? "R9 high elem" : (m != 0 ? "R4 unsigned" : "R3 packed"));

    // R5 low address bits ignored
    load(32'h3005, 4'd3, 1'b1, 7, "R5 low bits");
    load(32'h300F, 4'd6, 1'b0, 9, "R5 low bits");

    // R7 idle cycles with changing inputs
    e1 = result;
    addr = 32'h55; elem = 4'd9; mode = 1'b1; line = mk_line(77);
    repeat (3) @(negedge clk);
    check("R7 idle hold", result, e1);

    // R10 back-to-back: done and next capture in the same cycle
    addr = 32'h408; elem = 4'd5; mode = 1'b0; line = mk_line(11); req = 1'b1;
    e1 = expect_vec(addr, elem, mode, line);
    @(negedge clk);
    check("R10 first", result, e1);
    check("R10 done1", 128'(done), 128'(1));
    addr = 32'h500; elem = 4'd12; mode = 1'b1; line = mk_line(13);
    e2 = expect_vec(addr, elem, mode, line);
    @(negedge clk);
    req = 1'b0;
    check("R10 second", result, e2);
    check("R10 done2", 128'(done), 128'(1));
    @(negedge clk);
    check("R10 done drop", 128'(done), 128'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule